// File: doc/BRIEF.md
# Converter Mode Control Sequencer

This block holds the 8-bit operating-mode register of a sigma-delta converter pair and turns each software write into a short command sequence for the converter core. A 3-bit mode field chooses one of eight operations: power-down, idle, one-shot conversion, free-running conversion, and four calibrations. An enable bit gates whichever mode is stored. The core is reset on every write and then started. Done pulses that come back from each converter set ready flags and raise write strobes toward the data or calibration registers.

One-shot conversions and calibrations finish on their own. When the last converter reports, the block clears the mode field to power-down without any software action. The free-running mode never leaves by itself. A write that arrives while an operation is running aborts it and restarts the sequence under the new value. A 60 Hz notch request is kept only when the filter word is high enough for the filter to support it.

Top module: `adc_mode_seq`

## Requirements
- R1: After reset the register reads 0x10. `core_pd` is 1, and `rdy`, `core_start`, `dat_we` and `cal_we` are 0.
- R2: Every register write pulses `core_rst` for exactly one cycle in the cycle after the write. This holds even when the written value equals the stored one.
- R3: When enable (bit 5) is 1 and the mode field (bits 2:0) is 010, 011 or 1xx, `core_start` pulses in the cycle after `core_rst`, and `core_mode` then shows the mode. `in_sel` is 1 for 100 (internal short), 2 for 101 (reference), 3 for 110 and 111 (external calibration input), and 0 otherwise.
- R4: In mode 010, a done pulse on converter i pulses `dat_we[i]` and sets `rdy[i]` one cycle later. Once every converter has reported, the mode field reads 000 and `core_pd` is 1.
- R5: In mode 011, every round of done pulses produces `dat_we` strobes, and the mode field stays 011.
- R6: Launching a calibration mode clears all `rdy` bits. Done pulses then raise `cal_we[i]` instead of `dat_we[i]`, with `cal_full` equal to mode bit 0. After all converters have reported, the mode field returns to 000.
- R7: In mode 001 with enable set, `core_hold` is 1 and `core_start` stays 0. Done pulses produce no strobes.
- R8: The notch bit (bit 6) is stored as written only if `filt_word` is at least 68 at the time of the write; otherwise it is stored as 0. `notch_on` shows the stored bit.
- R9: With enable 0, the written mode field is stored and reads back. The block stays in power-down, does not start, and ignores done pulses.
- R10: A write during a running operation discards done pulses that arrive in the same cycle. It leaves `rdy` unchanged and starts the newly written mode.
- R11: `chop_off` follows bit 3 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Current register value |
| filt_word | input | FW | Filter word used to qualify the notch bit |
| core_rst | output | 1 | One-cycle converter reset |
| core_start | output | 1 | One-cycle operation start |
| core_pd | output | 1 | Converter is powered down |
| core_hold | output | 1 | Filter and modulator held in reset, clock running |
| core_mode | output | 3 | Operation in progress |
| in_sel | output | 2 | Input source: 0 channel, 1 short, 2 reference, 3 external cal input |
| chop_off | output | 1 | Chop disabled |
| notch_on | output | 1 | 60 Hz notch active |
| conv_done | input | NCONV | Per-converter completion pulse |
| rdy | output | NCONV | Per-converter ready flag |
| dat_we | output | NCONV | Data register write strobe |
| cal_we | output | NCONV | Calibration register write strobe |
| cal_full | output | 1 | Calibration strobe targets full-scale (1) or zero-scale (0) |

## Verification
The sequencer is driven with done pulses in several patterns: staggered across the two converters, simultaneous, repeated in the free-running mode, and arriving in the same cycle as a write. The staggered pattern tells per-converter tracking apart from a single shared completion. The repeated pattern separates the free-running mode from the self-clearing one-shot mode. Each calibration code is tried after the ready flags were set, which shows whether they are cleared on launch, and the writes that return the same value show whether a converter reset is issued regardless of change. Writes with enable low and with filter words of 67 and 68 probe the stored-but-inert and threshold paths.

// File: rtl/adc_mode_pkg.sv
package adc_mode_pkg;
   typedef enum logic [2:0] {
      MD_PD     = 3'd0,
      MD_IDLE   = 3'd1,
      MD_SINGLE = 3'd2,
      MD_CONT   = 3'd3,
      MD_ICZ    = 3'd4,
      MD_ICF    = 3'd5,
      MD_SCZ    = 3'd6,
      MD_SCF    = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      SQ_OFF    = 2'd0,
      SQ_LAUNCH = 2'd1,
      SQ_RUN    = 2'd2,
      SQ_HOLD   = 2'd3
   } seq_e;

   localparam int CHOP_BIT  = 3;
   localparam int EN_BIT    = 5;
   localparam int NOTCH_BIT = 6;

   // input source for an operation
   function automatic logic [1:0] src_of(mode_e m);
      case (m)
         MD_ICZ:         return 2'd1;
         MD_ICF:         return 2'd2;
         MD_SCZ, MD_SCF: return 2'd3;
         default:        return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/adc_mode_regs.sv
module adc_mode_regs
   import adc_mode_pkg::*;
#(
   parameter logic [7:0] RST_VAL   = 8'h10,
   parameter int         FW        = 8,
   parameter int         NOTCH_MIN = 68
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [7:0]    wdata,
   input  logic [FW-1:0] filt_word,
   input  logic          clr_mode,
   output logic [7:0]    q
);
   logic notch_ok;

   generate
      if (NOTCH_MIN <= 0) begin : g_no_gate
         assign notch_ok = 1'b1;
      end else begin : g_gate
         assign notch_ok = (32'(filt_word) >= NOTCH_MIN);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_VAL;
      end else if (wr) begin
         q <= wdata;
         q[NOTCH_BIT] <= wdata[NOTCH_BIT] & notch_ok;
      end else if (clr_mode) begin
         q[2:0] <= MD_PD;
      end
   end
endmodule

// File: rtl/adc_mode_fsm.sv
module adc_mode_fsm
   import adc_mode_pkg::*;
#(
   parameter int NCONV = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             en,
   input  mode_e            mode,
   input  logic [NCONV-1:0] done,
   output logic             clr_mode,
   output logic             core_rst,
   output logic             core_start,
   output seq_e             st,
   output mode_e            act_mode,
   output logic [NCONV-1:0] rdy,
   output logic [NCONV-1:0] dat_we,
   output logic [NCONV-1:0] cal_we,
   output logic             cal_full
);
   localparam logic [NCONV-1:0] ALL = {NCONV{1'b1}};

   logic [NCONV-1:0] pend;
   logic [NCONV-1:0] hits;
   logic [NCONV-1:0] pend_nxt;
   logic             last;
   logic             is_cal;

   assign is_cal = act_mode[2];

   // per-converter completion tracking
   generate
      for (genvar i = 0; i < NCONV; i++) begin : g_conv
         assign hits[i]     = done[i] & pend[i];
         assign pend_nxt[i] = pend[i] & ~done[i];
      end
   endgenerate

   assign last     = (st == SQ_RUN) && (|hits) && (pend_nxt == '0);
   assign clr_mode = last && !wr && (act_mode != MD_CONT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_OFF;
         act_mode   <= MD_PD;
         pend       <= '0;
         rdy        <= '0;
         dat_we     <= '0;
         cal_we     <= '0;
         cal_full   <= 1'b0;
         core_rst   <= 1'b0;
         core_start <= 1'b0;
      end else begin
         core_rst   <= wr;
         core_start <= 1'b0;
         dat_we     <= '0;
         cal_we     <= '0;
         if (wr) begin
            st <= SQ_LAUNCH;
         end else begin
            case (st)
               SQ_LAUNCH: begin
                  if (!en || mode == MD_PD) begin
                     st       <= SQ_OFF;
                     act_mode <= MD_PD;
                  end else if (mode == MD_IDLE) begin
                     st       <= SQ_HOLD;
                     act_mode <= MD_IDLE;
                  end else begin
                     st         <= SQ_RUN;
                     act_mode   <= mode;
                     pend       <= ALL;
                     core_start <= 1'b1;
                     if (mode[2]) rdy <= '0;
                  end
               end
               SQ_RUN: begin
                  rdy <= rdy | hits;
                  if (is_cal) begin
                     cal_we <= hits;
                     if (|hits) cal_full <= act_mode[0];
                  end else begin
                     dat_we <= hits;
                  end
                  if (last) begin
                     if (act_mode == MD_CONT) begin
                        pend <= ALL;
                     end else begin
                        pend     <= '0;
                        st       <= SQ_OFF;
                        act_mode <= MD_PD;
                     end
                  end else begin
                     pend <= pend_nxt;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/adc_mode_seq.sv
module adc_mode_seq
   import adc_mode_pkg::*;
#(
   parameter int         NCONV     = 2,
   parameter int         FW        = 8,
   parameter int         NOTCH_MIN = 68,
   parameter logic [7:0] RST_VAL   = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   input  logic [FW-1:0]    filt_word,
   output logic             core_rst,
   output logic             core_start,
   output logic             core_pd,
   output logic             core_hold,
   output logic [2:0]       core_mode,
   output logic [1:0]       in_sel,
   output logic             chop_off,
   output logic             notch_on,
   input  logic [NCONV-1:0] conv_done,
   output logic [NCONV-1:0] rdy,
   output logic [NCONV-1:0] dat_we,
   output logic [NCONV-1:0] cal_we,
   output logic             cal_full
);
   generate
      if (NCONV < 1) begin : g_bad_nconv
         $error("NCONV must be at least 1");
      end
      if (FW < 1 || FW > 31) begin : g_bad_fw
         $error("FW must lie in 1..31");
      end
   endgenerate

   logic  [7:0] reg_q;
   logic        clr_mode;
   seq_e        st;
   mode_e       act_mode;

   adc_mode_regs #(
      .RST_VAL   (RST_VAL),
      .FW        (FW),
      .NOTCH_MIN (NOTCH_MIN)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr),
      .wdata     (bus_wdata),
      .filt_word (filt_word),
      .clr_mode  (clr_mode),
      .q         (reg_q)
   );

   adc_mode_fsm #(
      .NCONV (NCONV)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .en         (reg_q[EN_BIT]),
      .mode       (mode_e'(reg_q[2:0])),
      .done       (conv_done),
      .clr_mode   (clr_mode),
      .core_rst   (core_rst),
      .core_start (core_start),
      .st         (st),
      .act_mode   (act_mode),
      .rdy        (rdy),
      .dat_we     (dat_we),
      .cal_we     (cal_we),
      .cal_full   (cal_full)
   );

   assign bus_rdata = reg_q;
   assign core_pd   = (st == SQ_OFF);
   assign core_hold = (st == SQ_HOLD);
   assign core_mode = act_mode;
   assign in_sel    = src_of(act_mode);
   assign chop_off  = reg_q[CHOP_BIT];
   assign notch_on  = reg_q[NOTCH_BIT];
endmodule

// File: rtl/adc_mode_seq_chk.sv
module adc_mode_seq_chk #(
   parameter int NCONV     = 2,
   parameter int FW        = 8,
   parameter int NOTCH_MIN = 68
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [7:0]       bus_rdata,
   input logic [FW-1:0]    filt_word,
   input logic             core_rst,
   input logic             core_start,
   input logic             core_pd,
   input logic             core_hold,
   input logic [2:0]       core_mode,
   input logic [NCONV-1:0] rdy,
   input logic [NCONV-1:0] dat_we,
   input logic [NCONV-1:0] cal_we
);
   p_wr_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> core_rst);

   p_start_after_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> $past(core_rst));

   p_cal_clears_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (core_start && core_mode[2]) |-> (rdy == '0));

   p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_hold |-> (bus_rdata[2:0] == 3'd1 && bus_rdata[5] && !core_start));

   p_notch_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && 32'(filt_word) < NOTCH_MIN) |=> !bus_rdata[6]);

   p_disabled_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rdata[5] && !core_rst) |-> core_pd);

   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !((|dat_we) && (|cal_we)));
endmodule

bind adc_mode_seq adc_mode_seq_chk #(
   .NCONV     (NCONV),
   .FW        (FW),
   .NOTCH_MIN (NOTCH_MIN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rdata  (bus_rdata),
   .filt_word  (filt_word),
   .core_rst   (core_rst),
   .core_start (core_start),
   .core_pd    (core_pd),
   .core_hold  (core_hold),
   .core_mode  (core_mode),
   .rdy        (rdy),
   .dat_we     (dat_we),
   .cal_we     (cal_we)
);

// File: tb/adc_mode_seq_tb.sv
`timescale 1ns/1ps
module adc_mode_seq_tb;
   localparam int NC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic [7:0]    filt_word = 8'd90;
   logic          core_rst, core_start, core_pd, core_hold, chop_off, notch_on, cal_full;
   logic [2:0]    core_mode;
   logic [1:0]    in_sel;
   logic [NC-1:0] conv_done = '0;
   logic [NC-1:0] rdy, dat_we, cal_we;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   adc_mode_seq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .filt_word(filt_word), .core_rst(core_rst),
      .core_start(core_start), .core_pd(core_pd), .core_hold(core_hold),
      .core_mode(core_mode), .in_sel(in_sel), .chop_off(chop_off),
      .notch_on(notch_on), .conv_done(conv_done), .rdy(rdy),
      .dat_we(dat_we), .cal_we(cal_we), .cal_full(cal_full)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      bus_wr = 1'b0;
      conv_done = '0;
      filt_word = 8'd90;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // write; returns at the negedge after the capturing edge
   task automatic wr(logic [7:0] d);
      bus_wr = 1'b1;
      bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic pulse_done(logic [NC-1:0] d);
      conv_done = d;
      @(negedge clk);
      conv_done = '0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 rdata", bus_rdata, 8'h10);
      chk("R1 pd", core_pd, 1);
      chk("R1 rdy", rdy, 0);
      chk("R1 strobes", {core_start, dat_we, cal_we}, 0);
   endtask

   task automatic t_single();
      do_reset();
      wr(8'h2A);
      chk("R2 core_rst", core_rst, 1);
      chk("R11 chop_off", chop_off, 1);
      @(negedge clk);
      chk("R2 one cycle", core_rst, 0);
      chk("R3 start", core_start, 1);
      chk("R3 mode", core_mode, 3'd2);
      chk("R3 in_sel", in_sel, 0);
      @(negedge clk);
      pulse_done(2'b01);
      chk("R4 dat_we0", dat_we, 2'b01);
      chk("R4 rdy0", rdy, 2'b01);
      chk("R4 still running", bus_rdata[2:0], 3'd2);
      pulse_done(2'b10);
      chk("R4 dat_we1", dat_we, 2'b10);
      chk("R4 rdy both", rdy, 2'b11);
      chk("R4 mode clr", bus_rdata, 8'h28);
      chk("R4 pd", core_pd, 1);
   endtask

   task automatic t_cont();
      do_reset();
      wr(8'h23);
      @(negedge clk);
      chk("R3 cont start", core_start, 1);
      for (int k = 0; k < 3; k++) begin
         pulse_done(2'b11);
         chk("R5 dat_we", dat_we, 2'b11);
         chk("R5 mode kept", bus_rdata[2:0], 3'd3);
      end
      chk("R5 not pd", core_pd, 0);
   endtask

   task automatic t_cal();
      for (int m = 4; m < 8; m++) begin
         do_reset();
         wr(8'h22);
         @(negedge clk);
         pulse_done(2'b11);
         chk("R6 rdy pre", rdy, 2'b11);
         wr(8'h20 | 8'(m));
         @(negedge clk);
         chk("R6 start", core_start, 1);
         chk("R6 rdy cleared", rdy, 0);
         chk("R3 in_sel cal", in_sel, (m == 4) ? 1 : (m == 5) ? 2 : 3);
         pulse_done(2'b11);
         chk("R6 cal_we", cal_we, 2'b11);
         chk("R6 dat_we quiet", dat_we, 0);
         chk("R6 cal_full", cal_full, m & 1);
         chk("R6 mode clr", bus_rdata[2:0], 0);
         chk("R6 rdy set", rdy, 2'b11);
      end
   endtask

   task automatic t_idle();
      do_reset();
      wr(8'h21);
      @(negedge clk);
      chk("R7 hold", core_hold, 1);
      chk("R7 no start", core_start, 0);
      pulse_done(2'b11);
      chk("R7 no strobe", {dat_we, cal_we, rdy}, 0);
   endtask

   task automatic t_disabled();
      do_reset();
      wr(8'h02);
      chk("R9 stored", bus_rdata, 8'h02);
      @(negedge clk);
      chk("R9 no start", core_start, 0);
      chk("R9 pd", core_pd, 1);
      pulse_done(2'b11);
      chk("R9 done ignored", {dat_we, rdy}, 0);
      wr(8'h02);
      chk("R2 same value rst", core_rst, 1);
   endtask

   task automatic t_notch();
      do_reset();
      filt_word = 8'd67;
      wr(8'h60);
      chk("R8 notch rejected", bus_rdata, 8'h20);
      filt_word = 8'd68;
      wr(8'h60);
      chk("R8 notch kept", bus_rdata, 8'h60);
      chk("R8 notch_on", notch_on, 1);
   endtask

   task automatic t_abort();
      do_reset();
      wr(8'h22);
      @(negedge clk);
      pulse_done(2'b01);
      chk("R10 rdy pre", rdy, 2'b01);
      conv_done = 2'b10;
      wr(8'h23);
      conv_done = '0;
      chk("R10 done dropped", dat_we, 0);
      chk("R10 rdy kept", rdy, 2'b01);
      chk("R10 mode kept", bus_rdata[2:0], 3'd3);
      @(negedge clk);
      chk("R10 restart", {core_start, core_mode}, {1'b1, 3'd3});
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      t_cont();
      t_cal();
      t_idle();
      t_disabled();
      t_notch();
      t_abort();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule